// File: doc/BRIEF.md
# Way Replacement Selector

This block chooses which way of a four-way set-associative cache set receives a new line when the controller allocates. Each cycle it looks at the valid bits of the addressed set. If any way is empty, the lowest-numbered empty way is the victim. If every way is full, a two-bit rotating pointer names the victim, and that pointer moves forward each time it is used for an allocation.

A lock input protects the lower half of the set (ways 0 and 1) from pointer-based replacement. While it is high, the pointer only ever names way 2 or way 3. The victim is a combinational function of the current inputs and the stored pointer, so the controller can use it in the same cycle as the request. The pointer update takes effect on the next rising clock edge. Tag and data storage, line fills and the writeback of dirty victims belong to the surrounding controller.

Top module: `way_victim_sel`

## Requirements
- R1: After synchronous active-low reset the pointer holds 0, so with all ways valid, lock low and no allocation, the victim index is 0.
- R2: When at least one valid bit is 0 and lock is low, the victim index is the lowest-numbered way whose valid bit is 0.
- R3: When all four valid bits are 1 and lock is low, the victim index equals the stored pointer.
- R4: An allocate strobe with all ways valid and lock low advances the pointer by one, wrapping from 3 to 0, at the next clock edge.
- R5: An allocate strobe while some way is invalid leaves the pointer unchanged.
- R6: With the allocate strobe low, the pointer does not change.
- R7: With lock high and all ways valid, the victim index is 2 or 3. If the pointer holds 0 or 1, the victim is 2. If it holds 2 or 3, the victim is the pointer.
- R8: An allocate strobe with lock high and all ways valid loads the pointer with 3 if the victim was 2, and with 2 if the victim was 3.
- R9: The one-hot victim output has exactly one bit set, at the position given by the victim index (bit i means way i).
- R10: With lock high, an invalid way still takes priority: the victim is the lowest-numbered invalid way, including ways 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_i | input | 1 | Allocation strobe for this cycle |
| half_lock_i | input | 1 | Restricts pointer-based choice to ways 2 and 3 |
| way_valid_i | input | 4 | Valid bit of each way of the addressed set, bit i is way i |
| victim_idx_o | output | 2 | Binary index of the chosen way |
| victim_oh_o | output | 4 | One-hot form of the chosen way |

## Verification
Two functions can coincide in one cycle: the combinational victim choice and the registered pointer advance. When an allocation is strobed with all ways valid, the same edge that consumes the current victim also moves the pointer. The sweep drives every combination of valid pattern, lock and strobe in a shuffled order, so allocations, lock toggles and empty ways fall on consecutive cycles. Each cycle the bench judges the victim against its arithmetic model, and the pointer change shows up in the victim of the next all-valid cycle. Lock is also raised while the pointer sits at 0 or 1, to check the forced move to way 2 in that same cycle.

// File: rtl/way_victim_pkg.sv
// Package: shared parameters and helpers for the way replacement selector.
// Assumes the way count is a power of two and at least 2.
package way_victim_pkg;

    localparam int unsigned DEF_NUM_WAYS = 4;

    // Width of a way index for a given way count.
    function automatic int unsigned idx_width(input int unsigned ways);
        return (ways <= 2) ? 1 : $clog2(ways);
    endfunction

endpackage

// File: rtl/way_free_pick.sv
// Module: way_free_pick
// Finds the lowest-numbered way whose valid bit is clear.
// Assumes a purely combinational use; any_free_o is low when all ways are valid,
// in which case free_idx_o is 0 and must be ignored.
module way_free_pick #(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned IDX_W   = way_victim_pkg::idx_width(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] valid_i,
    output logic                any_free_o,
    output logic [IDX_W-1:0]    free_idx_o
);

    // Scan from the top down so the lowest invalid way is written last.
    always_comb begin
        any_free_o = 1'b0;
        free_idx_o = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                any_free_o = 1'b1;
                free_idx_o = IDX_W'(w);
            end
        end
    end

endmodule

// File: rtl/way_rr_ptr.sv
// Module: way_rr_ptr
// Rotating replacement pointer with an optional lower-half lock.
// eff_o is the pointer as seen by the current cycle: under lock, a value in the
// lower half reads as the first upper-half way. On step_i the pointer loads the
// successor of eff_o, wrapping within the whole set or within the upper half.
// Assumes NUM_WAYS is a power of two; reset is synchronous and active low.
module way_rr_ptr #(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned IDX_W   = way_victim_pkg::idx_width(NUM_WAYS),
    localparam int unsigned HALF    = NUM_WAYS / 2,
    localparam int unsigned LAST    = NUM_WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] ptr_o,
    output logic [IDX_W-1:0] eff_o
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_nxt;

    // Effective pointer: lift into the upper half while locked.
    always_comb begin
        if (lock_i && (ptr_q < IDX_W'(HALF))) begin
            eff_o = IDX_W'(HALF);
        end else begin
            eff_o = ptr_q;
        end
    end

    // Successor: wrap inside the upper half when locked, else natural wrap.
    always_comb begin
        if (lock_i && (eff_o == IDX_W'(LAST))) begin
            ptr_nxt = IDX_W'(HALF);
        end else begin
            ptr_nxt = eff_o + IDX_W'(1);
        end
    end

    // Pointer register: cleared by reset, loaded only on a pointer-path step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (step_i) begin
            ptr_q <= ptr_nxt;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/way_idx_dec.sv
// Module: way_idx_dec
// Binary-to-one-hot decoder for a way index. Purely combinational.
module way_idx_dec #(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned IDX_W   = way_victim_pkg::idx_width(NUM_WAYS)
) (
    input  logic [IDX_W-1:0]    idx_i,
    output logic [NUM_WAYS-1:0] oh_o
);

    // One comparator per way.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_dec
        assign oh_o[g] = (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/way_victim_sel.sv
// Module: way_victim_sel (top)
// Picks the victim way of a set: the lowest invalid way if any exists,
// otherwise the rotating pointer (upper half only while locked). The choice
// is combinational; the pointer moves on the clock edge after an allocation
// that used it. Assumes the valid bits belong to the set being allocated.
module way_victim_sel #(
    parameter int unsigned NUM_WAYS = way_victim_pkg::DEF_NUM_WAYS,
    localparam int unsigned IDX_W   = way_victim_pkg::idx_width(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_i,
    input  logic                half_lock_i,
    input  logic [NUM_WAYS-1:0] way_valid_i,
    output logic [IDX_W-1:0]    victim_idx_o,
    output logic [NUM_WAYS-1:0] victim_oh_o
);

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_eff;
    logic             ptr_step;

    way_free_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .valid_i    (way_valid_i),
        .any_free_o (any_free),
        .free_idx_o (free_idx)
    );

    // The pointer is consumed only when no empty way exists.
    assign ptr_step = alloc_i && !any_free;

    way_rr_ptr #(.NUM_WAYS(NUM_WAYS)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_i (half_lock_i),
        .step_i (ptr_step),
        .ptr_o  (ptr_q),
        .eff_o  (ptr_eff)
    );

    // Victim select: empty way first, pointer otherwise.
    always_comb begin
        victim_idx_o = any_free ? free_idx : ptr_eff;
    end

    way_idx_dec #(.NUM_WAYS(NUM_WAYS)) u_dec (
        .idx_i (victim_idx_o),
        .oh_o  (victim_oh_o)
    );

endmodule

// File: rtl/way_victim_sel_chk.sv
// Module: way_victim_sel_chk
// Property checker for way_victim_sel, attached by the bind below.
module way_victim_sel_chk #(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned IDX_W   = way_victim_pkg::idx_width(NUM_WAYS),
    localparam int unsigned HALF    = NUM_WAYS / 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alloc_i,
    input logic                half_lock_i,
    input logic [NUM_WAYS-1:0] way_valid_i,
    input logic [IDX_W-1:0]    victim_idx_o,
    input logic [NUM_WAYS-1:0] victim_oh_o,
    input logic [IDX_W-1:0]    ptr_q
);

    logic full;
    assign full = &way_valid_i;

    // R1
    reset_clears_ptr_chk: assert property (@(posedge clk)
        !rst_n |=> ptr_q == '0);

    // R9
    onehot_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(victim_oh_o) && victim_oh_o[victim_idx_o]);

    // R2
    lowest_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !way_valid_i[victim_idx_o]
                  && ((way_valid_i & ((NUM_WAYS'(1) << victim_idx_o) - NUM_WAYS'(1)))
                      == ((NUM_WAYS'(1) << victim_idx_o) - NUM_WAYS'(1))));

    // R7
    lock_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && half_lock_i) |-> victim_idx_o >= IDX_W'(HALF));

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && full && !half_lock_i) |=> ptr_q == IDX_W'($past(ptr_q) + IDX_W'(1)));

    // R5
    ptr_hold_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !full) |=> $stable(ptr_q));

    // R6
    ptr_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_i |=> $stable(ptr_q));

    // R8
    lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && full && half_lock_i) |=> ptr_q >= IDX_W'(HALF) && ptr_q != $past(victim_idx_o));

endmodule

bind way_victim_sel way_victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (alloc_i),
    .half_lock_i  (half_lock_i),
    .way_valid_i  (way_valid_i),
    .victim_idx_o (victim_idx_o),
    .victim_oh_o  (victim_oh_o),
    .ptr_q        (ptr_q)
);

// File: tb/way_victim_sel_tb.sv
// Bench: directed steps then a shuffled sweep over every valid/lock/alloc
// combination, against an arithmetic pointer model.
module way_victim_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc = 1'b0;
    logic       lock = 1'b0;
    logic [3:0] valid = 4'hF;
    logic [1:0] vidx;
    logic [3:0] voh;

    int n_vec = 0;
    int n_bad = 0;
    int mptr = 0;

    always #2 clk = ~clk;

    way_victim_sel u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc),
        .half_lock_i  (lock),
        .way_valid_i  (valid),
        .victim_idx_o (vidx),
        .victim_oh_o  (voh)
    );

    // Drive one vector after an edge, check mid-cycle, then update the model.
    task automatic step(input logic [3:0] v, input logic lk, input logic al, input string tag);
        int exp_idx;
        int eff;
        int first_free;
        @(posedge clk);
        #1;
        valid = v;
        lock  = lk;
        alloc = al;
        #1;
        eff = (lk && mptr < 2) ? 2 : mptr;
        first_free = -1;
        for (int w = 3; w >= 0; w--) if (!v[w]) first_free = w;
        exp_idx = (first_free >= 0) ? first_free : eff;
        n_vec++;
        if (int'(vidx) != exp_idx) begin
            n_bad++;
            $display("FAIL %s idx got %0d exp %0d (valid=%b lock=%0b ptr=%0d)", tag, vidx, exp_idx, v, lk, mptr);
        end
        n_vec++;
        if (voh != (4'b1 << exp_idx)) begin
            n_bad++;
            $display("FAIL R9 onehot got %b exp %b", voh, 4'b1 << exp_idx);
        end
        if (al && first_free < 0) begin
            if (lk) mptr = (eff == 3) ? 2 : eff + 1;
            else    mptr = (eff + 1) % 4;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(4'hF, 1'b0, 1'b0, "R1");
        // R4: rotation through all ways with wrap
        for (int k = 0; k < 5; k++) step(4'hF, 1'b0, 1'b1, "R4");
        step(4'hF, 1'b0, 1'b0, "R3");
        // R2: holes at various positions
        step(4'b1011, 1'b0, 1'b1, "R2");
        step(4'b1110, 1'b0, 1'b1, "R2");
        step(4'b0111, 1'b0, 1'b0, "R2");
        // R5: the allocations above into free ways left the pointer
        step(4'hF, 1'b0, 1'b0, "R5");
        // R6: idle cycles keep the pointer
        step(4'hF, 1'b0, 1'b0, "R6");
        step(4'hF, 1'b1, 1'b0, "R6");
        step(4'hF, 1'b0, 1'b0, "R6");
        // R7: lock raised while pointer is low forces way 2
        step(4'hF, 1'b1, 1'b0, "R7");
        // R8: locked rotation alternates 2 and 3
        for (int k = 0; k < 4; k++) step(4'hF, 1'b1, 1'b1, "R8");
        step(4'hF, 1'b1, 1'b0, "R8");
        // R10: lock does not shield empty low ways
        step(4'b1110, 1'b1, 1'b1, "R10");
        step(4'b1101, 1'b1, 1'b0, "R10");
        // Sweep: all 64 combinations, shuffled, several passes
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 64; i++) begin
                int c;
                string t;
                c = (i * 37 + p * 11) % 64;
                if (c[4:1] == 4'hF) t = c[5] ? "R7" : "R3";
                else                t = c[5] ? "R10" : "R2";
                step(c[4:1], c[5], c[0], t);
            end
        end
        // Reset mid-run returns the pointer to 0
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        mptr = 0;
        step(4'hF, 1'b0, 1'b0, "R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule